// File: doc/BRIEF.md
# Device Key Self-Provisioning Sequencer

This block hands out a 128-bit key that is unique to one device, and it creates that key the first time it is asked for. On a request it drives the register port of a one-time-programmable fuse controller. It reads four key words in one burst. If any word is non-zero, the stored key is returned as it is. If all four words are zero, the block takes four 32-bit words from a random source and burns them into the same four fuse words, one program command per word, and then returns them.

Before each word is burned, the block reads that word again on its own. A fuse bit can only go from 0 to 1. If the new value would need a set bit to be cleared, the sequence fails. Otherwise only the bits that are still zero are programmed, and a word that needs no new bits gets no program command at all. Every fuse command runs the same way: pending status is cleared by reading the status register and writing the value back, the command and any program data are written, the start register is written, the status is polled, and the captured status bits are written back to clear them.

The requester raises `req_i` and holds it. The result is shown on `done_o` and `err_o` until `req_i` drops. Only one request is served at a time. A request can start only after the previous one has been released. The key registers are cleared when a result is released.

Top module: `huk_provisioner`

Top FSM states and transitions:
- IDLE → RD_ISSUE on request.
- RD_ISSUE → RD_WAIT.
- RD_WAIT → FAIL on a failed command, → RND if the key is all zero, → PASS otherwise.
- RND → CHK_ISSUE after the last random word.
- CHK_ISSUE → CHK_WAIT.
- CHK_WAIT → FAIL or CMP.
- CMP → FAIL on a conflict, → NEXT if the word is skipped, → PG_ISSUE otherwise.
- PG_ISSUE → PG_WAIT.
- PG_WAIT → FAIL or NEXT.
- NEXT → CHK_ISSUE for the next word, → PASS after the last word.
- PASS / FAIL → IDLE when `req_i` is low.

Command engine states, in order:
- E_IDLE, E_CLR_RD, E_CLR_WR, E_CTRL.
- E_PDATA, for program commands only.
- E_GO, E_POLL, E_EVAL.
- E_EVAL loops back to E_POLL until the command completes or the poll limit is reached.
- E_ACK.
- E_DOUT_RD and E_DOUT_CAP, repeated once per word, for successful reads only.
- E_DONE.

## Requirements
- R1: After reset, `done_o`, `err_o` and `rnd_ready_o` are 0, `key_o` is 0, and no fuse register access is made.
- R2: A request starts with one burst read. The command register at offset 0x04 is written with {index[15:0], 4'b0, count[3:0], 6'b0, cmd[1:0]}, using index 0x104, count 4 and cmd 0 (read). The start register at 0x08 is written with 1. Status sits at 0x84: bit 4 is error, bit 3 is program done, bit 2 is verify fail, bit 1 is read done. Read word i comes from 0x20+4i.
- R3: If any of the four words is non-zero, the key is reported unchanged with `key_o[32i+31:32i]` equal to fuse word 0x104+i. No program command is issued and no random word is taken.
- R4: If all four words are zero, four random words are taken. Random word i goes to fuse index 0x104+i with its own program command: command value {index, 16'h0002}, with the program data written at 0x10. The reported key is the random words.
- R5: Before each program command, that one word is read again with a count-1 read. If the new value would need a set bit cleared, the result is an error and that word gets no program command. Otherwise the program data is the new value with the already-set bits removed.
- R6: A word that needs no new bits gets no program command.
- R7: Pending status is zero every time the command register is written. Completion status is cleared by write-back before the result is reported.
- R8: An error bit, a verify-fail bit, or no completion within TIMEOUT_POLLS polls ends the request with `done_o` and `err_o` both 1 and `key_o` equal to 0.
- R9: `done_o` stays high while `req_i` is high and falls one cycle after `req_i` falls. `key_o` is non-zero only while `done_o` is 1 and `err_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Key request, held until the result is taken |
| done_o | output | 1 | Result valid |
| err_o | output | 1 | Result is an error |
| key_o | output | 128 | Key, valid with done and no error |
| rnd_valid_i | input | 1 | Random word available |
| rnd_data_i | input | 32 | Random word |
| rnd_ready_o | output | 1 | Random word accepted when valid |
| fc_re_o | output | 1 | Fuse controller register read |
| fc_we_o | output | 1 | Fuse controller register write |
| fc_addr_o | output | 8 | Register byte offset |
| fc_wdata_o | output | 32 | Write data |
| fc_rdata_i | input | 32 | Read data, valid the cycle after a read |

## Verification
The bench targets the following corner cases:
- A key with only one non-zero word. A design that tests only one word for emptiness would overwrite this key.
- Random words that are zero. A design that does not skip these would issue extra program commands.
- A reread word that already has some of the new bits set. A design that does not mask would program those bits again.
- A reread word with a bit outside the new value. A design that does not check for conflicts would burn the word anyway.
- Stale status bits left before a request. A design that does not clear first would send the command with status pending.
- Forced error, verify failure and a silent controller. A design that gets these wrong would report a stale or partial key, or hang.

// File: rtl/huk_pkg.sv
package huk_pkg;
    localparam logic [7:0] OFS_CTRL  = 8'h04;
    localparam logic [7:0] OFS_START = 8'h08;
    localparam logic [7:0] OFS_PDATA = 8'h10;
    localparam logic [7:0] OFS_DOUT  = 8'h20;
    localparam logic [7:0] OFS_STAT  = 8'h84;

    localparam int ST_ERR   = 4;
    localparam int ST_WDONE = 3;
    localparam int ST_VFAIL = 2;
    localparam int ST_RDONE = 1;

    localparam logic [1:0] CMD_READ = 2'd0;
    localparam logic [1:0] CMD_PROG = 2'd2;

    typedef enum logic {OP_READ, OP_PROG} op_e;

    typedef enum logic [3:0] {
        E_IDLE, E_CLR_RD, E_CLR_WR, E_CTRL, E_PDATA, E_GO,
        E_POLL, E_EVAL, E_ACK, E_DOUT_RD, E_DOUT_CAP, E_DONE
    } eng_state_e;

    typedef enum logic [3:0] {
        T_IDLE, T_RD_ISSUE, T_RD_WAIT, T_RND, T_CHK_ISSUE, T_CHK_WAIT,
        T_CMP, T_PG_ISSUE, T_PG_WAIT, T_NEXT, T_PASS, T_FAIL
    } top_state_e;
endpackage

// File: rtl/huk_fuse_cmd.sv
module huk_fuse_cmd
    import huk_pkg::*;
#(
    parameter int DATA_W        = 32,
    parameter int ADDR_W        = 8,
    parameter int TIMEOUT_POLLS = 1000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  op_e               op_i,
    input  logic [15:0]       index_i,
    input  logic [3:0]        count_i,
    input  logic [DATA_W-1:0] pdata_i,
    output logic              done_o,
    output logic              fail_o,
    output logic              word_valid_o,
    output logic [3:0]        word_idx_o,
    output logic [DATA_W-1:0] word_o,
    output logic              fc_re_o,
    output logic              fc_we_o,
    output logic [ADDR_W-1:0] fc_addr_o,
    output logic [DATA_W-1:0] fc_wdata_o,
    input  logic [DATA_W-1:0] fc_rdata_i
);
    localparam int TW = $clog2(TIMEOUT_POLLS + 1);

    eng_state_e        state_q;
    op_e               op_q;
    logic [15:0]       idx_q;
    logic [3:0]        cnt_q;
    logic [DATA_W-1:0] pdata_q;
    logic [DATA_W-1:0] st_q;
    logic [TW-1:0]     polls_q;
    logic [3:0]        wi_q;
    logic              fail_q;

    logic finished, bad;
    always_comb begin
        if (op_q == OP_READ) begin
            finished = fc_rdata_i[ST_RDONE] | fc_rdata_i[ST_ERR];
            bad      = fc_rdata_i[ST_ERR];
        end else begin
            finished = fc_rdata_i[ST_WDONE] | fc_rdata_i[ST_VFAIL] | fc_rdata_i[ST_ERR];
            bad      = fc_rdata_i[ST_VFAIL] | fc_rdata_i[ST_ERR];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= E_IDLE;
            op_q    <= OP_READ;
            idx_q   <= '0;
            cnt_q   <= '0;
            pdata_q <= '0;
            st_q    <= '0;
            polls_q <= '0;
            wi_q    <= '0;
            fail_q  <= 1'b0;
        end else begin
            unique case (state_q)
                E_IDLE: if (start_i) begin
                    op_q    <= op_i;
                    idx_q   <= index_i;
                    cnt_q   <= count_i;
                    pdata_q <= pdata_i;
                    fail_q  <= 1'b0;
                    polls_q <= '0;
                    wi_q    <= '0;
                    state_q <= E_CLR_RD;
                end
                E_CLR_RD: state_q <= E_CLR_WR;
                E_CLR_WR: state_q <= E_CTRL;
                E_CTRL:   state_q <= (op_q == OP_PROG) ? E_PDATA : E_GO;
                E_PDATA:  state_q <= E_GO;
                E_GO:     state_q <= E_POLL;
                E_POLL:   state_q <= E_EVAL;
                E_EVAL: begin
                    if (finished) begin
                        st_q    <= fc_rdata_i;
                        fail_q  <= bad;
                        state_q <= E_ACK;
                    end else if (polls_q == TW'(TIMEOUT_POLLS - 1)) begin
                        st_q    <= '0;
                        fail_q  <= 1'b1;
                        state_q <= E_ACK;
                    end else begin
                        polls_q <= polls_q + 1'b1;
                        state_q <= E_POLL;
                    end
                end
                E_ACK: state_q <= (op_q == OP_READ && !fail_q) ? E_DOUT_RD : E_DONE;
                E_DOUT_RD: state_q <= E_DOUT_CAP;
                E_DOUT_CAP: begin
                    wi_q    <= wi_q + 1'b1;
                    state_q <= (wi_q == 4'(cnt_q - 4'd1)) ? E_DONE : E_DOUT_RD;
                end
                E_DONE: state_q <= E_IDLE;
                default: state_q <= E_IDLE;
            endcase
        end
    end

    always_comb begin
        fc_re_o      = 1'b0;
        fc_we_o      = 1'b0;
        fc_addr_o    = '0;
        fc_wdata_o   = '0;
        done_o       = (state_q == E_DONE);
        fail_o       = (state_q == E_DONE) && fail_q;
        word_valid_o = (state_q == E_DOUT_CAP);
        word_idx_o   = wi_q;
        word_o       = fc_rdata_i;
        unique case (state_q)
            E_CLR_RD: begin fc_re_o = 1'b1; fc_addr_o = OFS_STAT; end
            E_CLR_WR: begin fc_we_o = 1'b1; fc_addr_o = OFS_STAT; fc_wdata_o = fc_rdata_i; end
            E_CTRL: begin
                fc_we_o    = 1'b1;
                fc_addr_o  = OFS_CTRL;
                fc_wdata_o = {idx_q, 4'b0, (op_q == OP_READ) ? cnt_q : 4'd0, 6'b0,
                              (op_q == OP_READ) ? CMD_READ : CMD_PROG};
            end
            E_PDATA: begin fc_we_o = 1'b1; fc_addr_o = OFS_PDATA; fc_wdata_o = pdata_q; end
            E_GO:    begin fc_we_o = 1'b1; fc_addr_o = OFS_START; fc_wdata_o = DATA_W'(1); end
            E_POLL:  begin fc_re_o = 1'b1; fc_addr_o = OFS_STAT; end
            E_ACK:   begin fc_we_o = 1'b1; fc_addr_o = OFS_STAT; fc_wdata_o = st_q; end
            E_DOUT_RD: begin
                fc_re_o   = 1'b1;
                fc_addr_o = ADDR_W'(OFS_DOUT + {wi_q, 2'b00});
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/huk_key_regs.sv
module huk_key_regs #(
    parameter int WORDS  = 4,
    parameter int DATA_W = 32
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      clr_i,
    input  logic                      wr_i,
    input  logic [$clog2(WORDS)-1:0]  widx_i,
    input  logic [DATA_W-1:0]         wdata_i,
    output logic [WORDS*DATA_W-1:0]   key_o,
    output logic                      empty_o
);
    for (genvar g = 0; g < WORDS; g++) begin : g_word
        logic [DATA_W-1:0] word_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                word_q <= '0;
            else if (clr_i)
                word_q <= '0;
            else if (wr_i && widx_i == g)
                word_q <= wdata_i;
        end
        assign key_o[g*DATA_W +: DATA_W] = word_q;
    end
    assign empty_o = ~|key_o;
endmodule

// File: rtl/huk_provisioner.sv
module huk_provisioner
    import huk_pkg::*;
#(
    parameter int DATA_W        = 32,
    parameter int ADDR_W        = 8,
    parameter int KEY_WORDS     = 4,
    parameter logic [15:0] KEY_INDEX = 16'h0104,
    parameter int TIMEOUT_POLLS = 1000
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        req_i,
    output logic                        done_o,
    output logic                        err_o,
    output logic [KEY_WORDS*DATA_W-1:0] key_o,
    input  logic                        rnd_valid_i,
    input  logic [DATA_W-1:0]           rnd_data_i,
    output logic                        rnd_ready_o,
    output logic                        fc_re_o,
    output logic                        fc_we_o,
    output logic [ADDR_W-1:0]           fc_addr_o,
    output logic [DATA_W-1:0]           fc_wdata_o,
    input  logic [DATA_W-1:0]           fc_rdata_i
);
    localparam int WW    = $clog2(KEY_WORDS);
    localparam int KEY_W = KEY_WORDS * DATA_W;

    top_state_e        state_q;
    logic [WW-1:0]     w_q;
    logic [DATA_W-1:0] old_q;

    logic              eng_start, eng_done, eng_fail, eng_wvalid;
    op_e               eng_op;
    logic [15:0]       eng_index;
    logic [3:0]        eng_count, eng_widx;
    logic [DATA_W-1:0] eng_pdata, eng_word, cur_word;
    logic              kr_clr, kr_wr, kr_empty;
    logic [WW-1:0]     kr_widx;
    logic [DATA_W-1:0] kr_wdata;
    logic [KEY_W-1:0]  key_flat;

    assign cur_word = key_flat[w_q*DATA_W +: DATA_W];

    huk_fuse_cmd #(
        .DATA_W(DATA_W), .ADDR_W(ADDR_W), .TIMEOUT_POLLS(TIMEOUT_POLLS)
    ) u_cmd (
        .clk(clk), .rst_n(rst_n),
        .start_i(eng_start), .op_i(eng_op), .index_i(eng_index),
        .count_i(eng_count), .pdata_i(eng_pdata),
        .done_o(eng_done), .fail_o(eng_fail),
        .word_valid_o(eng_wvalid), .word_idx_o(eng_widx), .word_o(eng_word),
        .fc_re_o(fc_re_o), .fc_we_o(fc_we_o), .fc_addr_o(fc_addr_o),
        .fc_wdata_o(fc_wdata_o), .fc_rdata_i(fc_rdata_i)
    );

    huk_key_regs #(.WORDS(KEY_WORDS), .DATA_W(DATA_W)) u_keys (
        .clk(clk), .rst_n(rst_n), .clr_i(kr_clr), .wr_i(kr_wr),
        .widx_i(kr_widx), .wdata_i(kr_wdata), .key_o(key_flat), .empty_o(kr_empty)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= T_IDLE;
            w_q     <= '0;
            old_q   <= '0;
        end else begin
            unique case (state_q)
                T_IDLE: begin
                    w_q <= '0;
                    if (req_i) state_q <= T_RD_ISSUE;
                end
                T_RD_ISSUE: state_q <= T_RD_WAIT;
                T_RD_WAIT: if (eng_done) begin
                    if (eng_fail)      state_q <= T_FAIL;
                    else if (kr_empty) state_q <= T_RND;
                    else               state_q <= T_PASS;
                end
                T_RND: if (rnd_valid_i) begin
                    if (w_q == WW'(KEY_WORDS - 1)) begin
                        w_q     <= '0;
                        state_q <= T_CHK_ISSUE;
                    end else begin
                        w_q <= w_q + 1'b1;
                    end
                end
                T_CHK_ISSUE: state_q <= T_CHK_WAIT;
                T_CHK_WAIT: begin
                    if (eng_wvalid) old_q <= eng_word;
                    if (eng_done) state_q <= eng_fail ? T_FAIL : T_CMP;
                end
                T_CMP: begin
                    if ((old_q & ~cur_word) != '0)      state_q <= T_FAIL;
                    else if ((cur_word & ~old_q) == '0) state_q <= T_NEXT;
                    else                                state_q <= T_PG_ISSUE;
                end
                T_PG_ISSUE: state_q <= T_PG_WAIT;
                T_PG_WAIT: if (eng_done) state_q <= eng_fail ? T_FAIL : T_NEXT;
                T_NEXT: begin
                    if (w_q == WW'(KEY_WORDS - 1)) begin
                        state_q <= T_PASS;
                    end else begin
                        w_q     <= w_q + 1'b1;
                        state_q <= T_CHK_ISSUE;
                    end
                end
                T_PASS, T_FAIL: if (!req_i) begin
                    old_q   <= '0;
                    state_q <= T_IDLE;
                end
                default: state_q <= T_IDLE;
            endcase
        end
    end

    always_comb begin
        eng_start = 1'b0;
        eng_op    = OP_READ;
        eng_index = KEY_INDEX + 16'(w_q);
        eng_count = 4'd1;
        eng_pdata = cur_word & ~old_q;
        kr_wr     = 1'b0;
        kr_widx   = w_q;
        kr_wdata  = rnd_data_i;
        kr_clr    = (state_q == T_PASS || state_q == T_FAIL) && !req_i;
        unique case (state_q)
            T_RD_ISSUE: begin
                eng_start = 1'b1;
                eng_index = KEY_INDEX;
                eng_count = 4'(KEY_WORDS);
            end
            T_RD_WAIT: begin
                kr_wr    = eng_wvalid;
                kr_widx  = WW'(eng_widx);
                kr_wdata = eng_word;
            end
            T_RND:       kr_wr = rnd_valid_i;
            T_CHK_ISSUE: eng_start = 1'b1;
            T_PG_ISSUE: begin
                eng_start = 1'b1;
                eng_op    = OP_PROG;
            end
            default: ;
        endcase
        done_o      = (state_q == T_PASS) || (state_q == T_FAIL);
        err_o       = (state_q == T_FAIL);
        key_o       = (state_q == T_PASS) ? key_flat : '0;
        rnd_ready_o = (state_q == T_RND);
    end
endmodule

// File: rtl/huk_provisioner_sva.sv
module huk_provisioner_sva #(
    parameter int KEY_W = 128
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_i,
    input logic             done_o,
    input logic             err_o,
    input logic [KEY_W-1:0] key_o,
    input logic             rnd_ready_o,
    input logic             fc_re_o,
    input logic             fc_we_o
);
    AST_KEY_HIDDEN: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> key_o == '0);                                   // R9
    AST_FAIL_NO_KEY: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> done_o && key_o == '0);                           // R8
    AST_DONE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        done_o && req_i |=> done_o);                                // R9
    AST_DONE_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o && !req_i |=> !done_o);                              // R9
    AST_DONE_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_o) |-> $past(req_i));                            // R9
    AST_ONE_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
        !(fc_re_o && fc_we_o));                                     // R2
    AST_QUIET_WHEN_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !fc_re_o && !fc_we_o && !rnd_ready_o);           // R7
endmodule

bind huk_provisioner huk_provisioner_sva #(.KEY_W(KEY_WORDS*DATA_W)) u_sva (
    .clk(clk), .rst_n(rst_n), .req_i(req_i), .done_o(done_o), .err_o(err_o),
    .key_o(key_o), .rnd_ready_o(rnd_ready_o), .fc_re_o(fc_re_o), .fc_we_o(fc_we_o)
);

// File: tb/huk_provisioner_test.sv
module huk_provisioner_test;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         req_i = 1'b0;
    logic         done_o, err_o, rnd_ready_o;
    logic [127:0] key_o;
    logic         rnd_valid_i = 1'b0;
    logic [31:0]  rnd_data_i;
    logic         fc_re_o, fc_we_o;
    logic [7:0]   fc_addr_o;
    logic [31:0]  fc_wdata_o;
    logic [31:0]  fc_rdata_i = '0;

    always #10 clk = ~clk;

    huk_provisioner #(.TIMEOUT_POLLS(20)) uut (
        .clk(clk), .rst_n(rst_n), .req_i(req_i), .done_o(done_o), .err_o(err_o),
        .key_o(key_o), .rnd_valid_i(rnd_valid_i), .rnd_data_i(rnd_data_i),
        .rnd_ready_o(rnd_ready_o), .fc_re_o(fc_re_o), .fc_we_o(fc_we_o),
        .fc_addr_o(fc_addr_o), .fc_wdata_o(fc_wdata_o), .fc_rdata_i(fc_rdata_i)
    );

    int checks = 0;
    int errors = 0;

    // fuse controller model
    logic [31:0] mem [4];
    logic [31:0] ghost [4];
    logic [31:0] dout [8];
    logic [4:0]  stat;
    logic [31:0] ctrl_q, pdata_q;
    int          pend;
    bit          f_err, f_vfail, f_silent;
    int          n_ctrl, n_prog, n_single, clr_viol;
    logic [31:0] ctrl_log [16];
    logic [31:0] pg_ctrl [8];
    logic [31:0] pg_data [8];

    // random source stub
    logic [31:0] rng [4];
    int          rp;
    assign rnd_data_i = rng[rp[1:0]];

    function automatic logic [31:0] fuse_word(logic [15:0] idx, bit single);
        int k = int'(idx) - 32'h104;
        if (k < 0 || k > 3) return 32'h0;
        return mem[k] | (single ? ghost[k] : 32'h0);
    endfunction

    function automatic logic [31:0] exp_ctrl(logic [15:0] idx, logic [3:0] cnt, logic [1:0] cmd);
        return {idx, 4'b0, cnt, 6'b0, cmd};
    endfunction

    always @(posedge clk) begin
        if (rnd_valid_i && rnd_ready_o) rp <= rp + 1;
        if (fc_re_o) begin
            if (fc_addr_o == 8'h84) fc_rdata_i <= {27'b0, stat};
            else if (fc_addr_o >= 8'h20 && fc_addr_o < 8'h40) fc_rdata_i <= dout[(fc_addr_o - 8'h20) >> 2];
            else fc_rdata_i <= 32'h0;
        end
        if (pend == 1 && !f_silent) begin
            if (ctrl_q[1:0] == 2'd0) begin
                for (int i = 0; i < 8; i++)
                    if (i < int'(ctrl_q[11:8]))
                        dout[i] <= fuse_word(ctrl_q[31:16] + 16'(i), ctrl_q[11:8] == 4'd1);
                stat <= stat | (f_err ? 5'b10000 : 5'b00010);
            end else if (f_vfail) begin
                stat <= stat | 5'b00100;
            end else begin
                if (int'(ctrl_q[31:16]) >= 32'h104 && int'(ctrl_q[31:16]) < 32'h108)
                    mem[int'(ctrl_q[31:16]) - 32'h104] <= mem[int'(ctrl_q[31:16]) - 32'h104] | pdata_q;
                stat <= stat | (f_err ? 5'b10000 : 5'b01000);
            end
        end
        if (pend > 0) pend <= pend - 1;
        if (fc_we_o) begin
            unique case (fc_addr_o)
                8'h04: begin
                    if (stat != 5'b0) clr_viol <= clr_viol + 1;
                    ctrl_q <= fc_wdata_o;
                    if (n_ctrl < 16) ctrl_log[n_ctrl] <= fc_wdata_o;
                    n_ctrl <= n_ctrl + 1;
                    if (fc_wdata_o[1:0] == 2'd2) begin
                        if (n_prog < 8) pg_ctrl[n_prog] <= fc_wdata_o;
                        n_prog <= n_prog + 1;
                    end
                    if (fc_wdata_o[1:0] == 2'd0 && fc_wdata_o[11:8] == 4'd1) n_single <= n_single + 1;
                end
                8'h10: begin
                    pdata_q <= fc_wdata_o;
                    if (n_prog > 0 && n_prog <= 8) pg_data[n_prog-1] <= fc_wdata_o;
                end
                8'h08: if (fc_wdata_o[0]) pend <= 3;
                8'h84: stat <= stat & ~fc_wdata_o[4:0];
                default: ;
            endcase
        end
    end

    task automatic model_reset(input logic [127:0] stored);
        for (int i = 0; i < 4; i++) begin
            mem[i] = stored[32*i +: 32];
            ghost[i] = '0;
        end
        for (int i = 0; i < 8; i++) begin
            dout[i] = '0;
            pg_ctrl[i] = '0;
            pg_data[i] = '0;
        end
        stat = '0; pend = 0; f_err = 0; f_vfail = 0; f_silent = 0;
        n_ctrl = 0; n_prog = 0; n_single = 0; clr_viol = 0; rp = 0;
    endtask

    task automatic chk(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    logic [127:0] got_key;
    bit           got_err;
    bit           got_done;

    task automatic run_req(input int hold);
        int n = 0;
        @(negedge clk);
        req_i = 1'b1;
        while (!done_o && n < 4000) begin
            rnd_valid_i = ($urandom % 3) != 0;
            @(negedge clk);
            n++;
        end
        rnd_valid_i = 1'b0;
        got_done = done_o;
        got_key = key_o;
        got_err = err_o;
        for (int i = 0; i < hold; i++) begin
            @(negedge clk);
            chk(done_o == 1'b1, "R9 done held while req high", 128'(done_o), 128'd1);
        end
        req_i = 1'b0;
        @(negedge clk);
        @(negedge clk);
    endtask

    function automatic logic [127:0] rng_key();
        return {rng[3], rng[2], rng[1], rng[0]};
    endfunction

    function automatic logic [127:0] mem_key();
        return {mem[3], mem[2], mem[1], mem[0]};
    endfunction

    initial begin
        #(20 * 150000);
        errors++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [127:0] stored;
        int exp_prog;
        void'($urandom(32'h5eed_1234));
        for (int i = 0; i < 4; i++) rng[i] = '0;
        model_reset('0);
        repeat (3) @(negedge clk);
        chk(!done_o && !err_o && key_o == '0 && !rnd_ready_o && !fc_re_o && !fc_we_o,
            "R1 reset state", {125'b0, done_o, err_o, rnd_ready_o}, 128'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // stored key, stale status before the request
        stored = {$urandom, $urandom, $urandom, $urandom | 32'h1};
        model_reset(stored);
        stat = 5'b11110;
        run_req(3);
        chk(got_done && !got_err && got_key == stored, "R3 stored key reported", got_key, stored);
        chk(n_prog == 0 && rp == 0, "R3 no program, no random", 128'(n_prog * 16 + rp), 128'd0);
        chk(ctrl_log[0] == exp_ctrl(16'h104, 4'd4, 2'd0), "R2 burst read command", 128'(ctrl_log[0]),
            128'(exp_ctrl(16'h104, 4'd4, 2'd0)));
        chk(n_ctrl == 1, "R2 single burst", 128'(n_ctrl), 128'd1);
        chk(clr_viol == 0 && stat == 5'b0, "R7 status cleared", 128'(clr_viol * 32 + int'(stat)), 128'd0);
        chk(done_o == 1'b0 && key_o == '0, "R9 release clears result", key_o, 128'd0);

        // only the top word non-zero
        stored = {32'h0000_0100, 96'h0};
        model_reset(stored);
        run_req(0);
        chk(!got_err && got_key == stored && n_prog == 0, "R3 partial key kept", got_key, stored);

        // empty key, all random words non-zero
        model_reset('0);
        for (int i = 0; i < 4; i++) rng[i] = $urandom | 32'h8000_0000;
        stat = 5'b01010;
        run_req(1);
        chk(!got_err && got_key == rng_key(), "R4 provisioned key", got_key, rng_key());
        chk(mem_key() == rng_key(), "R4 fuses burned", mem_key(), rng_key());
        chk(n_prog == 4 && rp == 4, "R4 four program commands", 128'(n_prog), 128'd4);
        for (int i = 0; i < 4; i++)
            chk(pg_ctrl[i] == {16'h104 + 16'(i), 16'h0002}, "R4 program command word",
                128'(pg_ctrl[i]), 128'({16'h104 + 16'(i), 16'h0002}));
        chk(n_single == 4, "R5 reread per word", 128'(n_single), 128'd4);
        chk(clr_viol == 0 && stat == 5'b0, "R7 clear around every command", 128'(clr_viol), 128'd0);

        // one random word zero: that word skipped
        model_reset('0);
        rng[0] = 32'h1234_5678; rng[1] = 32'h0; rng[2] = 32'h0F00_0001; rng[3] = 32'hFFFF_FFFF;
        run_req(0);
        chk(!got_err && got_key == rng_key(), "R6 key with zero word", got_key, rng_key());
        chk(n_prog == 3, "R6 zero word skipped", 128'(n_prog), 128'd3);

        // reread shows some bits already set: only missing bits programmed
        model_reset('0);
        rng[0] = 32'h1; rng[1] = 32'h2; rng[2] = 32'hA5A5_F00F; rng[3] = 32'h4;
        ghost[2] = 32'h0505_000F;
        run_req(0);
        chk(!got_err && got_key == rng_key(), "R5 masked key", got_key, rng_key());
        chk(pg_data[2] == 32'hA0A0_F000, "R5 masked program data", 128'(pg_data[2]), 128'hA0A0_F000);

        // reread shows all bits set already: skip
        model_reset('0);
        rng[0] = 32'h11; rng[1] = 32'h22; rng[2] = 32'h33; rng[3] = 32'h44;
        ghost[3] = 32'h44;
        run_req(0);
        chk(!got_err && n_prog == 3, "R6 already-set word skipped", 128'(n_prog), 128'd3);

        // conflict on word 1
        model_reset('0);
        rng[0] = 32'h0000_000F; rng[1] = 32'h0000_00F0; rng[2] = 32'h1; rng[3] = 32'h2;
        ghost[1] = 32'h0000_0001;
        run_req(0);
        chk(got_done && got_err && got_key == '0, "R5 conflict error", {127'b0, got_err}, 128'd1);
        chk(n_prog == 1, "R5 conflict word not programmed", 128'(n_prog), 128'd1);

        // error on the burst read
        model_reset({4{32'hDEAD_BEEF}});
        f_err = 1;
        run_req(0);
        chk(got_done && got_err && got_key == '0 && rp == 0, "R8 read error", {127'b0, got_err}, 128'd1);

        // verify failure on program
        model_reset('0);
        for (int i = 0; i < 4; i++) rng[i] = 32'h100 + 32'(i);
        f_vfail = 1;
        run_req(0);
        chk(got_done && got_err && got_key == '0, "R8 verify fail", {127'b0, got_err}, 128'd1);

        // silent controller
        model_reset({4{32'h0000_0001}});
        f_silent = 1;
        run_req(0);
        chk(got_done && got_err && got_key == '0, "R8 timeout", {127'b0, got_err}, 128'd1);

        // random mix
        for (int it = 0; it < 16; it++) begin
            bit empty = ($urandom % 2) == 1;
            stored = empty ? 128'h0 : {$urandom, $urandom, $urandom, $urandom};
            model_reset(stored);
            exp_prog = 0;
            for (int i = 0; i < 4; i++) begin
                rng[i] = ($urandom % 4 == 0) ? 32'h0 : $urandom;
                if (rng[i] != 0) exp_prog++;
            end
            if ($urandom % 2 == 1) stat = 5'($urandom);
            run_req(int'($urandom % 3));
            if (stored != 0) begin
                chk(!got_err && got_key == stored && n_prog == 0, "R3 random stored", got_key, stored);
            end else if (rng_key() == 0) begin
                chk(!got_err && got_key == 0 && n_prog == 0, "R6 random all-zero draw", got_key, 128'd0);
            end else begin
                chk(!got_err && got_key == rng_key() && n_prog == exp_prog, "R4 random provision",
                    got_key, rng_key());
            end
            chk(clr_viol == 0, "R7 random clear", 128'(clr_viol), 128'd0);
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule